// File: doc/BRIEF.md
# Interrupt Enable and Pending State Bank

This block holds the per-line state that an interrupt controller keeps for a set of interrupt lines: whether each line is enabled, whether an event is waiting on it (pending), and whether its handler is in progress (active). The lines are packed 32 to a word, so that line n sits in word n/32 at bit n%32. Software reaches the state through a small synchronous register port. Enable and pending each have a separate set alias and a separate clear alias, so one line can be changed without a read-modify-write sequence.

A rising edge on a raw interrupt input records the line as pending, whether or not the line is enabled. The block drives a ready vector, with one bit per line, to a downstream priority arbiter. A line is ready when it is pending, enabled and not active. The arbiter returns an acknowledge carrying a line index. The acknowledge moves that line from pending to active. A later completion carrying a line index clears its active bit. Choosing among the ready lines, fetching vectors and exception entry are handled outside this block.

Top module: `irq_state_bank`

## Requirements
- R1: A synchronous reset clears every enable, pending and active bit. After reset every readable word returns zero and `ready_o` is all zero.
- R2: A write to the set-enable group (address group 0) enables every line whose data bit is 1. Line n is word n/32, bit n%32, and the word index is address bits [1:0]. A 0 bit leaves the line unchanged.
- R3: A write to the clear-enable group (group 1) disables every line whose data bit is 1. A 0 bit leaves the line unchanged.
- R4: A read of either group 0 or group 1 returns the current enable word, with 1 meaning enabled.
- R5: A write to the set-pending group (group 2) sets pending for each data bit of 1. A write to the clear-pending group (group 3) clears pending for each data bit of 1. A 0 bit has no effect. A read of group 2 or group 3 returns the pending word.
- R6: A rising edge on `irq_in[n]` sets pending for line n even while line n is disabled. A disabled line never appears in `ready_o`.
- R7: `ready_o[n]` is 1 exactly when line n is pending, enabled and not active.
- R8: An acknowledge (`ack_valid` with `ack_line`) clears that line's pending bit and sets its active bit on the same clock edge. A read of group 4 returns the active word. Writes to group 4 change nothing.
- R9: A completion (`done_valid` with `done_line`) clears that line's active bit. If an acknowledge names the same line in the same cycle, the acknowledge wins.
- R10: If an input edge and a clear-pending write hit the same line in one cycle, the line ends up pending. If an input edge and an acknowledge hit the same line in one cycle, the line also ends up pending.
- R11: Address groups 5, 6 and 7 read as zero, and writes to them change no state.
- R12: `reg_rdata` shows the word addressed in the previous cycle, as it stood before that cycle's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address: bits [4:2] select the group, bits [1:0] select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_in | input | 128 | Raw interrupt inputs; a rising edge marks the line pending |
| ack_valid | input | 1 | Arbiter acknowledge strobe |
| ack_line | input | 7 | Index of the acknowledged line |
| done_valid | input | 1 | Completion strobe |
| done_line | input | 7 | Index of the completed line |
| ready_o | output | 128 | Lines that are pending, enabled and not active |

## Verification
The bench sets up all three state types through the set aliases, the clear aliases and zero-valued writes. It writes a word in one alias and reads it back through the other alias, which shows that both aliases address the same storage. An input edge on a disabled line is compared with the same edge after the line is enabled, which separates latching pending from offering the line for activation. The bench then applies a same-cycle edge together with a clear-pending write, and an acknowledge followed by a completion, which show the set-wins rule and the active-masking term of the ready vector. Writes to the read-only group and to unmapped groups show that those addresses leave every state bit unchanged.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int GRP_W = 3;

    typedef enum logic [GRP_W-1:0] {
        GRP_EN_SET   = 3'd0,
        GRP_EN_CLR   = 3'd1,
        GRP_PEND_SET = 3'd2,
        GRP_PEND_CLR = 3'd3,
        GRP_ACTIVE   = 3'd4
    } grp_e;

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int DATA_W    = 32,
    localparam int WORDS    = NUM_LINES / DATA_W,
    localparam int WORD_AW  = $clog2(WORDS),
    localparam int ADDR_W   = GRP_W + WORD_AW
) (
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_LINES-1:0] en_set,
    output logic [NUM_LINES-1:0] en_clr,
    output logic [NUM_LINES-1:0] pend_set,
    output logic [NUM_LINES-1:0] pend_clr
);

    logic [GRP_W-1:0]   grp;
    logic [WORD_AW-1:0] word;

    assign grp  = addr[ADDR_W-1 -: GRP_W];
    assign word = addr[WORD_AW-1:0];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic hit;
        assign hit = we && (word == WORD_AW'(w));
        assign en_set[w*DATA_W +: DATA_W]   = (hit && grp == GRP_EN_SET)   ? wdata : '0;
        assign en_clr[w*DATA_W +: DATA_W]   = (hit && grp == GRP_EN_CLR)   ? wdata : '0;
        assign pend_set[w*DATA_W +: DATA_W] = (hit && grp == GRP_PEND_SET) ? wdata : '0;
        assign pend_clr[w*DATA_W +: DATA_W] = (hit && grp == GRP_PEND_CLR) ? wdata : '0;
    end

endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int NUM_LINES = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] rise
);

    logic [NUM_LINES-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = rst ? '0 : irq_in;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

    assign rise = irq_in & ~prev_q;

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int DATA_W    = 32,
    localparam int WORDS    = NUM_LINES / DATA_W,
    localparam int WORD_AW  = $clog2(WORDS),
    localparam int ADDR_W   = GRP_W + WORD_AW
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LINES-1:0] en,
    input  logic [NUM_LINES-1:0] pend,
    input  logic [NUM_LINES-1:0] act,
    output logic [DATA_W-1:0]    rdata
);

    logic [GRP_W-1:0]   grp;
    logic [WORD_AW-1:0] word;

    assign grp  = addr[ADDR_W-1 -: GRP_W];
    assign word = addr[WORD_AW-1:0];

    always_comb begin
        case (grp)
            GRP_EN_SET, GRP_EN_CLR:     rdata = en[word*DATA_W +: DATA_W];
            GRP_PEND_SET, GRP_PEND_CLR: rdata = pend[word*DATA_W +: DATA_W];
            GRP_ACTIVE:                 rdata = act[word*DATA_W +: DATA_W];
            default:                    rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int DATA_W    = 32,
    localparam int WORDS    = NUM_LINES / DATA_W,
    localparam int WORD_AW  = $clog2(WORDS),
    localparam int ADDR_W   = GRP_W + WORD_AW,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_line,
    input  logic                 done_valid,
    input  logic [IDX_W-1:0]     done_line,
    output logic [NUM_LINES-1:0] ready_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] en;
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] act;
        logic [DATA_W-1:0]    rdata;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [NUM_LINES-1:0] en_set, en_clr, pend_set, pend_clr;
    logic [NUM_LINES-1:0] irq_rise;
    logic [NUM_LINES-1:0] ack_vec, done_vec;
    logic [NUM_LINES-1:0] en_q, pend_q, act_q;
    logic [DATA_W-1:0]    rd_word;

    localparam logic [NUM_LINES-1:0] ONE_HOT0 = NUM_LINES'(1);

    irq_wr_decode #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_wr_decode (
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .pend_set (pend_set),
        .pend_clr (pend_clr)
    );

    irq_edge_detect #(.NUM_LINES(NUM_LINES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .rise   (irq_rise)
    );

    irq_rd_mux #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_rd_mux (
        .addr  (reg_addr),
        .en    (en_q),
        .pend  (pend_q),
        .act   (act_q),
        .rdata (rd_word)
    );

    always_comb begin
        ack_vec  = ack_valid  ? (ONE_HOT0 << ack_line)  : '0;
        done_vec = done_valid ? (ONE_HOT0 << done_line) : '0;

        bank_d       = bank_q;
        bank_d.en    = (bank_q.en | en_set) & ~en_clr;
        // set sources are ORed last so an edge beats any clear in the same cycle
        bank_d.pend  = (bank_q.pend & ~pend_clr & ~ack_vec) | pend_set | irq_rise;
        bank_d.act   = (bank_q.act & ~done_vec) | ack_vec;
        bank_d.rdata = rd_word;

        if (rst) begin
            bank_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    assign en_q      = bank_q.en;
    assign pend_q    = bank_q.pend;
    assign act_q     = bank_q.act;
    assign reg_rdata = bank_q.rdata;
    assign ready_o   = bank_q.pend & bank_q.en & ~bank_q.act;

endmodule

// File: rtl/irq_state_bank_chk.sv
module irq_state_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int DATA_W    = 32,
    localparam int WORDS    = NUM_LINES / DATA_W,
    localparam int WORD_AW  = $clog2(WORDS),
    localparam int ADDR_W   = GRP_W + WORD_AW,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_we,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic                 ack_valid,
    input logic [IDX_W-1:0]     ack_line,
    input logic                 done_valid,
    input logic [IDX_W-1:0]     done_line,
    input logic [NUM_LINES-1:0] rise,
    input logic [NUM_LINES-1:0] en_q,
    input logic [NUM_LINES-1:0] act_q,
    input logic [NUM_LINES-1:0] pend_q
);

    logic [GRP_W-1:0] grp;
    assign grp = reg_addr[ADDR_W-1 -: GRP_W];

    // R3: enable state moves only on a register write
    assert_enable_only_by_write_R3: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(en_q));

    // R6, R10: an input edge always leaves its line pending
    assert_edge_sets_pending_R6: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R8: acknowledge makes the line active
    assert_ack_sets_active_R8: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> act_q[$past(ack_line)]);

    // R8: no line turns active without an acknowledge
    assert_active_only_by_ack_R8: assert property (@(posedge clk) disable iff (rst)
        !ack_valid |=> ((act_q & ~$past(act_q)) == '0));

    // R9: completion clears active unless an acknowledge names the same line
    assert_done_clears_active_R9: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !(ack_valid && ack_line == done_line)) |=> !act_q[$past(done_line)]);

    // R11: unmapped groups read as zero
    assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (grp > GRP_W'(GRP_ACTIVE)) |=> (reg_rdata == '0));

endmodule

bind irq_state_bank irq_state_bank_chk #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .ack_valid  (ack_valid),
    .ack_line   (ack_line),
    .done_valid (done_valid),
    .done_line  (done_line),
    .rise       (irq_rise),
    .en_q       (en_q),
    .act_q      (act_q),
    .pend_q     (pend_q)
);

// File: tb/irq_state_bank_tb.sv
module irq_state_bank_tb;

    localparam int N  = 128;
    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [N-1:0]  irq_in = '0;
    logic          ack_valid = 1'b0;
    logic [6:0]    ack_line = '0;
    logic          done_valid = 1'b0;
    logic [6:0]    done_line = '0;
    logic [N-1:0]  ready_o;

    always #2 clk = ~clk;

    irq_state_bank u_dut (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_in     (irq_in),
        .ack_valid  (ack_valid),
        .ack_line   (ack_line),
        .done_valid (done_valid),
        .done_line  (done_line),
        .ready_o    (ready_o)
    );

    // reference state, derived from the requirements
    logic [N-1:0] en_m = '0, pend_m = '0, act_m = '0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    bit            issue = 1'b0;
    int            vectors = 0;
    int            miscompares = 0;

    function automatic logic [DW-1:0] model_word(int grp, int word);
        case (grp)
            0, 1:    return en_m[word*DW +: DW];
            2, 3:    return pend_m[word*DW +: DW];
            4:       return act_m[word*DW +: DW];
            default: return '0;
        endcase
    endfunction

    task automatic drive_idle();
        reg_we = 1'b0; ack_valid = 1'b0; done_valid = 1'b0; issue = 1'b0;
    endtask

    task automatic tick_idle();
        @(negedge clk); drive_idle();
    endtask

    task automatic wr(int grp, int word, logic [DW-1:0] data);
        logic [N-1:0] m;
        @(negedge clk); drive_idle();
        reg_we = 1'b1; reg_addr = {3'(grp), 2'(word)}; reg_wdata = data;
        m = N'(data) << (word*DW);
        case (grp)
            0: en_m   = en_m | m;
            1: en_m   = en_m & ~m;
            2: pend_m = pend_m | m;
            3: pend_m = pend_m & ~m;
            default: ;
        endcase
    endtask

    task automatic rd(int grp, int word, string tag);
        @(negedge clk); drive_idle();
        reg_addr = {3'(grp), 2'(word)}; issue = 1'b1;
        exp_q.push_back(model_word(grp, word));
        tag_q.push_back(tag);
    endtask

    task automatic irq_up(int line);
        @(negedge clk); drive_idle();
        irq_in[line] = 1'b1; pend_m[line] = 1'b1;
    endtask

    task automatic irq_down(int line);
        @(negedge clk); drive_idle();
        irq_in[line] = 1'b0;
    endtask

    task automatic ack(int line);
        @(negedge clk); drive_idle();
        ack_valid = 1'b1; ack_line = 7'(line);
        pend_m[line] = 1'b0; act_m[line] = 1'b1;
    endtask

    task automatic done(int line);
        @(negedge clk); drive_idle();
        done_valid = 1'b1; done_line = 7'(line);
        act_m[line] = 1'b0;
    endtask

    task automatic clr_with_edge(int line);
        @(negedge clk); drive_idle();
        reg_we = 1'b1; reg_addr = {3'd3, 2'(line / DW)};
        reg_wdata = DW'(1) << (line % DW);
        irq_in[line] = 1'b1;
        pend_m[line] = 1'b1;
    endtask

    task automatic chk_ready(string tag);
        logic [N-1:0] exp;
        @(negedge clk); drive_idle();
        exp = en_m & pend_m & ~act_m;
        vectors++;
        if (ready_o !== exp) begin
            miscompares++;
            $display("FAIL %s ready_o actual=%h expected=%h", tag, ready_o, exp);
        end
    endtask

    // monitor: pops one expected word per read issued in the previous cycle
    initial begin
        forever begin
            bit armed;
            logic [DW-1:0] e;
            string t;
            @(posedge clk);
            armed = issue;
            #1;
            if (armed) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                vectors++;
                if (reg_rdata !== e) begin
                    miscompares++;
                    $display("FAIL %s reg_rdata actual=%h expected=%h", t, reg_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: everything clear after reset
        chk_ready("R1");
        for (int g = 0; g < 5; g++)
            for (int w = 0; w < 4; w++)
                rd(g, w, "R1");

        // R2 / R4: set-enable, zero bits inert, both aliases read back
        wr(0, 1, 32'h0000_0005);
        rd(0, 1, "R2");
        rd(1, 1, "R4");
        wr(0, 1, 32'h0);
        rd(0, 1, "R2");

        // R3: clear-enable
        wr(1, 1, 32'h0000_0001);
        rd(0, 1, "R3");
        wr(1, 1, 32'h0);
        rd(1, 1, "R3");

        // R6: edge on disabled line 70 latches pending, not offered
        irq_up(70);
        irq_down(70);
        rd(2, 2, "R6");
        chk_ready("R6");
        wr(0, 2, 32'h0000_0040);
        chk_ready("R7");

        // R5: pending aliases
        wr(2, 3, 32'h8000_0001);
        rd(3, 3, "R5");
        wr(3, 3, 32'h0000_0001);
        rd(2, 3, "R5");
        wr(3, 3, 32'h0);
        rd(2, 3, "R5");

        // R8: acknowledge moves 70 to active; active group is read-only
        ack(70);
        rd(4, 2, "R8");
        rd(2, 2, "R8");
        chk_ready("R7");
        wr(4, 2, 32'hFFFF_FFFF);
        rd(4, 2, "R8");
        rd(4, 0, "R8");

        // R7: active masks a pending enabled line
        wr(2, 2, 32'h0000_0040);
        chk_ready("R7");

        // R9: completion clears active, line 70 becomes ready again
        done(70);
        rd(4, 2, "R9");
        chk_ready("R9");

        // R10: edge and clear-pending on line 5 in the same cycle
        clr_with_edge(5);
        irq_down(5);
        rd(2, 0, "R10");

        // R11: unmapped groups
        wr(5, 0, 32'hFFFF_FFFF);
        wr(7, 3, 32'hFFFF_FFFF);
        rd(5, 0, "R11");
        rd(6, 1, "R11");
        rd(7, 3, "R11");
        rd(0, 0, "R11");
        rd(2, 0, "R11");
        chk_ready("R11");

        // R12: back-to-back reads of different words each land one cycle later
        rd(0, 2, "R12");
        rd(2, 3, "R12");
        rd(4, 2, "R12");

        tick_idle();
        tick_idle();
        tick_idle();
        if (exp_q.size() != 0) begin
            miscompares++;
            $display("FAIL R12 pending reads actual=%0d expected=0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule